// File: doc/BRIEF.md
# Cartridge ROM Bank and SRAM Mapper

This block sits on the cartridge side of a 68000-style system bus with a 24-bit byte address and 16-bit big-endian data. It turns every bus address in the lower 4 MiB cartridge space into a physical ROM address. It does this through a table of eight bank registers. Each register selects which 512 KiB page of ROM appears in one 512 KiB window of the CPU's view. Bank register 0 is fixed at zero, so the reset vectors always come from the first ROM page. Bank registers 1 to 7 can be written by software.

Battery SRAM can overlay the upper half of the cartridge space whenever address bit 21 is set. Two things control the overlay: a control register that holds an enable bit and a write-permit bit, and a parameter that says whether SRAM is fitted at all. By default the write-permit bit is stored but not enforced, because some software clears it and still expects its saves to land. Software reaches all control registers through a 256-byte register window. Reads of that window return zero. The physical ROM and SRAM addresses are masked to power-of-two sizes, so an access beyond the fitted size wraps.

Top module: `cart_mapper`

## Requirements
- R1: Register writes take effect only for bus writes with addresses 0xA13000 to 0xA130FF. A write outside that window leaves all mapper state unchanged. A write inside the window to an offset other than 0xF0 to 0xFF also leaves all mapper state unchanged.
- R2: A write to 0xA130F1 loads the SRAM enable from data bit 0 and the SRAM write-permit flag from data bit 1.
- R3: A write to 0xA130F1+2k, for k from 1 to 7, loads bank register k from data bits 5:0. Data bits 7:6 are dropped.
- R4: Bank register 0 always holds 0. No register write can change it.
- R5: For a cartridge read, rom_addr_o equals ({bank[addr[21:19]], addr[18:0]}) masked to ROM_AW bits.
- R6: After reset the SRAM enable and write-permit flags are both 1, and bank register n holds n. This gives an identity ROM mapping.
- R7: sram_sel_o is 1 on a read or write exactly when all of the following hold: addr[23:22] is 0, addr[21] is 1, SRAM is present, and the SRAM enable is 1. rom_sel_o is 1 on a cartridge read that does not select SRAM. The two are never 1 together.
- R8: SRAM byte-lane strobes follow big-endian lanes. sram_we_o[1] writes the even byte (data 15:8) when be[1] is set, and sram_we_o[0] writes the odd byte (data 7:0) when be[0] is set. sram_addr_o is the bus address masked to SRAM_AW bits.
- R9: With ENFORCE_WP=0, SRAM writes proceed whatever the write-permit flag holds. With ENFORCE_WP=1, SRAM writes are blocked while the flag is 0.
- R10: An access inside the register window raises reg_sel_o, and a read there returns rdata_o = 0x0000. Accesses outside the window leave reg_sel_o low.
- R11: A register loads only when low-lane strobe be[0] is set, and it always takes the low data byte. A word write to the even address beside a register loads that register from bits 7:0. A write with only be[1] set does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 24 | Bus byte address |
| bus_wdata_i | input | 16 | Bus write data, big-endian |
| bus_be_i | input | 2 | Byte lanes: [1] even byte, [0] odd byte |
| bus_rd_i | input | 1 | Read cycle |
| bus_wr_i | input | 1 | Write cycle |
| rom_addr_o | output | ROM_AW | Physical ROM byte address |
| rom_sel_o | output | 1 | ROM read select |
| sram_addr_o | output | SRAM_AW | Physical SRAM byte address |
| sram_sel_o | output | 1 | SRAM select |
| sram_we_o | output | 2 | SRAM byte-lane write strobes |
| reg_sel_o | output | 1 | Register window access |
| rdata_o | output | 16 | Register window read data |

## Verification
The assertions check the following on every cycle: a register load stores exactly the written bits, the bank table holds steady when no register write occurs, SRAM selection agrees with address bit 21 and the enable bit, ROM and SRAM are never selected together, the low 19 ROM address bits pass through unchanged, and the write-permit rule holds when it is enforced. The bench scenarios cover the things the assertions cannot see. These are the bank-to-window correspondence for every window, wrap-around from masking, the reset identity map, and the fact that stray writes leave the mapping intact. They also cover the lane rules for word and byte register writes, and the difference between the two write-permit parameter settings.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int unsigned BUS_AW    = 24;
  localparam int unsigned BANK_W    = 6;
  localparam int unsigned NUM_BANKS = 8;
  localparam int unsigned PAGE_AW   = 19;
  localparam logic [15:0] WIN_HI    = 16'hA130;
  localparam logic [3:0]  REG_NIB   = 4'hF;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_tbl_t;
endpackage

// File: rtl/cart_map_win.sv
module cart_map_win
  import cart_map_pkg::*;
(
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              win_hit_o,
  output logic              reg_wr_o,
  output logic [2:0]        reg_idx_o,
  output logic [7:0]        reg_data_o
);
  logic unused_bits;
  assign unused_bits = ^{wdata_i[15:8], addr_i[0], be_i[1]};

  assign win_hit_o  = (addr_i[23:8] == WIN_HI) && (rd_i || wr_i);
  // registers live at odd offsets F1..FF; addr[0] ignored so word writes hit them
  assign reg_wr_o   = wr_i && (addr_i[23:8] == WIN_HI) && (addr_i[7:4] == REG_NIB) && be_i[0];
  assign reg_idx_o  = addr_i[3:1];
  assign reg_data_o = wdata_i[7:0];
endmodule

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] data_i,
  output bank_tbl_t  bank_o,
  output logic       sram_en_o,
  output logic       sram_wp_o
);
  bank_tbl_t bank_q;
  logic      en_q, wp_q;
  logic      unused_data;
  assign unused_data = ^data_i[7:6];

  assign bank_q[0] = '0;  // page 0 is pinned

  for (genvar k = 1; k < NUM_BANKS; k++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      bank_q[k] <= bank_t'(k);
      else if (wr_i && idx_i == 3'(k))  bank_q[k] <= data_i[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
      wp_q <= 1'b1;
    end else if (wr_i && idx_i == 3'd0) begin
      en_q <= data_i[0];
      wp_q <= data_i[1];
    end
  end

  assign bank_o    = bank_q;
  assign sram_en_o = en_q;
  assign sram_wp_o = wp_q;

  // R3
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i != 3'd0) |=> bank_o[$past(idx_i)] == $past(data_i[BANK_W-1:0]));
  // R1
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bank_o) && $stable(sram_en_o) && $stable(sram_wp_o));
  // R2
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 3'd0) |=> (sram_en_o == $past(data_i[0])) && (sram_wp_o == $past(data_i[1])));
endmodule

// File: rtl/cart_map_route.sv
module cart_map_route
  import cart_map_pkg::*;
#(
  parameter int unsigned ROM_AW       = 22,
  parameter int unsigned SRAM_AW      = 15,
  parameter bit          SRAM_PRESENT = 1'b1,
  parameter bit          ENFORCE_WP   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  bank_tbl_t         bank_i,
  input  logic              sram_en_i,
  input  logic              sram_wp_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_sel_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic              sram_sel_o,
  output logic [1:0]        sram_we_o
);
  localparam int unsigned FULL_AW = BANK_W + PAGE_AW;

  logic               cart_hit, sram_hit, wr_ok;
  logic [FULL_AW-1:0] full_addr;
  bank_t              page;

  assign cart_hit  = (addr_i[23:22] == 2'b00);
  assign sram_hit  = cart_hit && addr_i[21] && SRAM_PRESENT && sram_en_i;
  assign page      = bank_i[addr_i[21:19]];
  assign full_addr = {page, addr_i[PAGE_AW-1:0]};

  assign wr_ok       = ENFORCE_WP ? sram_wp_i : 1'b1;
  assign rom_addr_o  = full_addr[ROM_AW-1:0];
  assign rom_sel_o   = rd_i && cart_hit && !sram_hit;
  assign sram_addr_o = addr_i[SRAM_AW-1:0];
  assign sram_sel_o  = (rd_i || wr_i) && sram_hit;
  assign sram_we_o   = be_i & {2{wr_i && sram_hit && wr_ok}};

  // R7
  sram_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_sel_o |-> addr_i[21] && sram_en_i && !rom_sel_o);
  // R7
  rom_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o |-> !sram_sel_o && (addr_i[23:22] == 2'b00));
  // R5
  rom_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o |-> rom_addr_o[PAGE_AW-1:0] == addr_i[PAGE_AW-1:0]);
  // R9
  wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ENFORCE_WP && sram_we_o != 2'b00) |-> sram_wp_i);
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_map_pkg::*;
#(
  parameter int unsigned ROM_AW       = 22,
  parameter int unsigned SRAM_AW      = 15,
  parameter bit          SRAM_PRESENT = 1'b1,
  parameter bit          ENFORCE_WP   = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [23:0]        bus_addr_i,
  input  logic [15:0]        bus_wdata_i,
  input  logic [1:0]         bus_be_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  output logic [ROM_AW-1:0]  rom_addr_o,
  output logic               rom_sel_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic               sram_sel_o,
  output logic [1:0]         sram_we_o,
  output logic               reg_sel_o,
  output logic [15:0]        rdata_o
);
  logic       reg_wr, sram_en, sram_wp;
  logic [2:0] reg_idx;
  logic [7:0] reg_data;
  bank_tbl_t  bank_tbl;

  cart_map_win u_win (
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .be_i       (bus_be_i),
    .rd_i       (bus_rd_i),
    .wr_i       (bus_wr_i),
    .win_hit_o  (reg_sel_o),
    .reg_wr_o   (reg_wr),
    .reg_idx_o  (reg_idx),
    .reg_data_o (reg_data)
  );

  cart_map_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr),
    .idx_i     (reg_idx),
    .data_i    (reg_data),
    .bank_o    (bank_tbl),
    .sram_en_o (sram_en),
    .sram_wp_o (sram_wp)
  );

  cart_map_route #(
    .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW),
    .SRAM_PRESENT(SRAM_PRESENT), .ENFORCE_WP(ENFORCE_WP)
  ) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (bus_addr_i),
    .be_i        (bus_be_i),
    .rd_i        (bus_rd_i),
    .wr_i        (bus_wr_i),
    .bank_i      (bank_tbl),
    .sram_en_i   (sram_en),
    .sram_wp_i   (sram_wp),
    .rom_addr_o  (rom_addr_o),
    .rom_sel_o   (rom_sel_o),
    .sram_addr_o (sram_addr_o),
    .sram_sel_o  (sram_sel_o),
    .sram_we_o   (sram_we_o)
  );

  assign rdata_o = 16'h0000;  // window reads back as zero

  // R10
  win_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_o |-> !rom_sel_o && !sram_sel_o);
endmodule

// File: tb/cart_mapper_tb_top.sv
module cart_mapper_tb_top;
  localparam int ROM_AW  = 22;
  localparam int SRAM_AW = 15;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [23:0]        addr = '0;
  logic [15:0]        wdata = '0;
  logic [1:0]         be = '0;
  logic               rd = 1'b0, wr = 1'b0;
  logic [ROM_AW-1:0]  rom_addr,  rom_addr_w;
  logic               rom_sel,   rom_sel_w;
  logic [SRAM_AW-1:0] sram_addr, sram_addr_w;
  logic               sram_sel,  sram_sel_w;
  logic [1:0]         sram_we,   sram_we_w;
  logic               reg_sel,   reg_sel_w;
  logic [15:0]        rdata,     rdata_w;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_bank [8];

  always #5 clk = ~clk;

  cart_mapper #(.ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_be_i(be), .bus_rd_i(rd), .bus_wr_i(wr),
    .rom_addr_o(rom_addr), .rom_sel_o(rom_sel), .sram_addr_o(sram_addr),
    .sram_sel_o(sram_sel), .sram_we_o(sram_we), .reg_sel_o(reg_sel), .rdata_o(rdata));

  cart_mapper #(.ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW), .ENFORCE_WP(1'b1)) dut_wp_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_be_i(be), .bus_rd_i(rd), .bus_wr_i(wr),
    .rom_addr_o(rom_addr_w), .rom_sel_o(rom_sel_w), .sram_addr_o(sram_addr_w),
    .sram_sel_o(sram_sel_w), .sram_we_o(sram_we_w), .reg_sel_o(reg_sel_w), .rdata_o(rdata_w));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [23:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0; be = 2'b00;
  endtask

  task automatic bus_rd(input logic [23:0] a);
    @(negedge clk);
    addr = a; be = 2'b11; rd = 1'b1; wr = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] rom_exp(input logic [23:0] a);
    logic [31:0] full;
    full = (32'(exp_bank[a[21:19]]) << 19) | 32'(a[18:0]);
    return full & ((32'd1 << ROM_AW) - 1);
  endfunction

  task automatic sweep_map(input string req);
    logic [18:0] offs [3];
    offs[0] = 19'h00000; offs[1] = 19'h7FFFE; offs[2] = 19'h12345;
    for (int w = 0; w < 8; w++)
      for (int o = 0; o < 3; o++) begin
        logic [23:0] a;
        a = {2'b00, 3'(w), offs[o]};
        bus_rd(a);
        chk(req, 32'(rom_addr), rom_exp(a));
        chk(req, 32'(rom_addr_w), rom_exp(a));
      end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_bank[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: identity map, SRAM enabled and writable
    sweep_map("R6");
    bus_rd(24'h200000);
    chk("R6", {sram_sel, rom_sel}, 2'b10);
    @(negedge clk); addr = 24'h200000; be = 2'b11; rd = 0; wr = 1; #1;
    chk("R6", {sram_we, sram_we_w}, 4'b1111);
    @(negedge clk); wr = 0; be = 0;

    // R2 R11: word write at F0, low byte 0 disables SRAM, high byte ignored
    bus_wr(24'hA130F0, 16'hFF00, 2'b11);
    bus_rd(24'h200000);
    chk("R2", {sram_sel, rom_sel}, 2'b01);
    chk("R11", 32'(rom_addr), rom_exp(24'h200000));

    // R3 R5: load every bank, bits 7:6 set to confirm truncation
    for (int k = 1; k < 8; k++) begin
      int v;
      v = (k * 13 + 5) & 63;
      exp_bank[k] = v;
      bus_wr(24'hA130F1 + 24'(2 * k), {8'h55, 2'b11, 6'(v)}, 2'b01);
    end
    sweep_map("R3");
    // R4: bank 0 still maps page 0
    bus_rd(24'h012345);
    chk("R4", 32'(rom_addr), 32'h012345);

    // R1: writes outside window or to non-register offsets
    bus_wr(24'hA12FF3, 16'h003F, 2'b11);
    bus_wr(24'hA131F3, 16'h003F, 2'b11);
    bus_wr(24'hA130E3, 16'h003F, 2'b11);
    bus_wr(24'hA13073, 16'h003F, 2'b01);
    sweep_map("R1");
    // R11: high-lane-only write ignored
    bus_wr(24'hA130F2, 16'h3F3F, 2'b10);
    bus_rd(24'h080000);
    chk("R11", 32'(rom_addr), rom_exp(24'h080000));
    // R11: word write at even address F2 loads bank 1 from low byte
    bus_wr(24'hA130F2, 16'h2A01, 2'b11);
    exp_bank[1] = 1;
    bus_rd(24'h080010);
    chk("R11", 32'(rom_addr), rom_exp(24'h080010));

    // R10: window reads
    bus_rd(24'hA130F3);
    chk("R10", {reg_sel, rom_sel, sram_sel}, 3'b100);
    chk("R10", 32'(rdata), 32'h0);
    bus_rd(24'hA13100);
    chk("R10", 32'(reg_sel), 32'h0);

    // R2 R7: enable with write-permit cleared
    bus_wr(24'hA130F1, 16'h0001, 2'b01);
    bus_rd(24'h200000);
    chk("R7", {sram_sel, rom_sel}, 2'b10);
    bus_rd(24'h1FFFFE);
    chk("R7", {sram_sel, rom_sel}, 2'b01);
    bus_rd(24'h600000);
    chk("R7", {sram_sel, rom_sel}, 2'b00);
    bus_rd(24'h3FFFFE);
    chk("R7", {sram_sel, rom_sel}, 2'b10);

    // R9: write-permit 0
    @(negedge clk); addr = 24'h200000; be = 2'b11; rd = 0; wr = 1; #1;
    chk("R9", 32'(sram_we), 32'h3);
    chk("R9", 32'(sram_we_w), 32'h0);
    @(negedge clk); wr = 0; be = 0;
    bus_wr(24'hA130F1, 16'h0003, 2'b01);
    // R8: byte lanes and SRAM address mask
    @(negedge clk); addr = 24'h20ABCD; be = 2'b10; wr = 1; #1;
    chk("R8", 32'(sram_we), 32'h2);
    chk("R9", 32'(sram_we_w), 32'h2);
    chk("R8", 32'(sram_addr), 32'h2BCD);
    be = 2'b01; #1;
    chk("R8", 32'(sram_we), 32'h1);
    @(negedge clk); wr = 0; be = 0;

    // R6: reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) exp_bank[i] = i;
    sweep_map("R6");
    bus_rd(24'h200000);
    chk("R6", 32'(sram_sel), 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule